// File: doc/BRIEF.md
# Programmable Flag Threshold Offset Bank

This block stores the two threshold offsets that a dual-clock, 9-bit-wide FIFO compares against its fill level to raise its almost-empty and almost-full warnings. Each offset is 15 bits wide and is kept in two registers, an 8-bit low part and a 7-bit high part. That makes four registers, and every access path visits them in the same fixed order: empty-low, empty-high, full-low, full-high.

There are two ways to load the registers, both in the write-clock domain. The first shifts in one bit per edge on a serial input. The second takes one whole register per edge from the data bus. A third path reads the registers back onto the output bus in the read-clock domain, one register per read edge.

Serial loading, parallel loading and readback each keep their own position. Any of the three can be stopped for ordinary FIFO traffic and later continued from the register or bit where it stopped. The two offsets are also presented as plain vectors, for the flag comparators outside this block.

Top module: `ofs_bank`

## Requirements
- R1: After master reset, both offsets equal 127 (empty_ofs and full_ofs read 15'h007F), dout is zero, ser_done is low, and all three access positions point at the start of the sequence.
- R2: With ld_n and sen_n both low on a wclk rising edge, the bit on si is stored at the serial position, which then advances. The 30 positions run through empty-low bits 0..7, then empty-high bits 0..6, then full-low bits 0..7, then full-high bits 0..6, least significant bit first. empty_ofs is {empty-high, empty-low} and full_ofs is {full-high, full-low}.
- R3: After the 30th serial bit, the serial position returns to empty-low bit 0, and ser_done is high for exactly the one wclk cycle after that edge.
- R4: A wclk edge with ld_n low and sen_n high (and wen_n high), or with ld_n high, stores nothing and leaves the serial position where it was, so a serial load continues with the next bit once both inputs return low.
- R5: With ld_n low, sen_n high and wen_n low on a wclk rising edge, din is written into the register at the parallel position (order empty-low, empty-high, full-low, full-high). The position then advances, and the fifth write lands in empty-low again.
- R6: A parallel write stores din[7:0] into a low register and din[6:0] into a high register. The remaining din bits are ignored.
- R7: A wclk edge with ld_n high, or with wen_n high, leaves the parallel position unchanged, so a parallel sequence continues at the next register after any amount of memory traffic.
- R8: When sen_n and wen_n are both low with ld_n low, only the serial bit is stored. The parallel position does not move.
- R9: With ld_n and ren_n both low on an rclk rising edge, dout receives the register at the read position, zero-extended to 9 bits. The read position then advances through the same four-register order and wraps to empty-low after full-high.
- R10: The read position moves only on readback edges. It is not moved by register writes. An rclk edge without readback leaves both dout and the read position unchanged.
- R11: While part_rst is high, no load or readback takes place. The offsets and all three positions are kept, and sequences continue from where they were once part_rst falls.
- R12: Master reset asserted in the middle of a sequence returns it to its first register or bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock; all loads happen on its rising edge |
| rclk | input | 1 | Read clock; readback happens on its rising edge |
| mst_rst | input | 1 | Master reset, active high, asynchronous |
| part_rst | input | 1 | Partial reset, active high; suspends access, keeps contents and positions |
| ld_n | input | 1 | Register access select, active low |
| sen_n | input | 1 | Serial load enable, active low |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| si | input | 1 | Serial offset bit |
| din | input | 9 | Parallel write data |
| dout | output | 9 | Readback data, registered on rclk |
| empty_ofs | output | 15 | Current empty threshold offset |
| full_ofs | output | 15 | Current full threshold offset |
| ser_done | output | 1 | One-cycle pulse after a complete serial load |

## Verification
The bound checker tests the position rules on every cycle. It checks that each position moves one step on its own access edge, that the serial position wraps after the last bit with a single done pulse, and that nothing moves while no access is enabled or partial reset is high. It also checks that serial priority leaves the parallel position alone, that readback of a high register zero-extends, and that the offsets never change without a load. Only the bench's scenarios can show which data ends up where: the serial bit mapping, the parallel order with its wraparound and the ignored din bits, readback contents, reads staying separate from writes, and positions starting over after a mid-sequence master reset.

// File: rtl/ofsbank_pkg.sv
package ofsbank_pkg;

   // Order in which every access path visits the four offset registers.
   typedef enum logic [1:0] {
      REG_EMP_LO = 2'd0,
      REG_EMP_HI = 2'd1,
      REG_FUL_LO = 2'd2,
      REG_FUL_HI = 2'd3
   } ofs_reg_e;

   localparam int N_OFS_REG = 4;

   // Register holding bit 'pos' of the flat vector {full, empty}.
   function automatic int unsigned reg_of_bit(int unsigned pos, int unsigned lo_w, int unsigned ofs_w);
      int unsigned in_ofs;
      in_ofs = pos % ofs_w;
      return (pos / ofs_w) * 2 + ((in_ofs >= lo_w) ? 1 : 0);
   endfunction

   // Bit position of flat bit 'pos' inside its register.
   function automatic int unsigned bit_in_reg(int unsigned pos, int unsigned lo_w, int unsigned ofs_w);
      int unsigned in_ofs;
      in_ofs = pos % ofs_w;
      return (in_ofs >= lo_w) ? in_ofs - lo_w : in_ofs;
   endfunction

endpackage

// File: rtl/ofs_seq_ptr.sv
module ofs_seq_ptr #(
   parameter int N_REG = 4,
   localparam int PTR_W = (N_REG > 1) ? $clog2(N_REG) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   output logic [PTR_W-1:0] ptr
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(N_REG - 1);

   always_ff @(posedge clk or posedge rst) begin
      if (rst)
         ptr <= '0;
      else if (adv)
         ptr <= (ptr == LAST) ? '0 : ptr + PTR_W'(1);
   end
endmodule

// File: rtl/ofs_ser_ctr.sv
module ofs_ser_ctr #(
   parameter int TOT_W = 30,
   localparam int CNT_W = $clog2(TOT_W)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   output logic [CNT_W-1:0] idx,
   output logic             done
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TOT_W - 1);

   logic at_last;
   assign at_last = (idx == LAST);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         idx  <= '0;
         done <= 1'b0;
      end else begin
         done <= adv && at_last;
         if (adv)
            idx <= at_last ? '0 : idx + CNT_W'(1);
      end
   end
endmodule

// File: rtl/ofs_store.sv
module ofs_store #(
   parameter int LO_W    = 8,
   parameter int HI_W    = 7,
   parameter int DATA_W  = 9,
   parameter int DEF_OFS = 127,
   localparam int OFS_W  = LO_W + HI_W,
   localparam int TOT_W  = 2 * OFS_W,
   localparam int CNT_W  = $clog2(TOT_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ser_we,
   input  logic [CNT_W-1:0]  ser_idx,
   input  logic              si,
   input  logic              par_we,
   input  logic [1:0]        par_sel,
   input  logic [DATA_W-1:0] din,
   output logic [TOT_W-1:0]  ofs_vec
);
   import ofsbank_pkg::*;

   localparam logic [OFS_W-1:0] DEF_ONE = OFS_W'(DEF_OFS);
   localparam logic [TOT_W-1:0] DEF_VEC = {DEF_ONE, DEF_ONE};

   // One flop per offset bit. The serial and parallel addresses of each bit are fixed at elaboration.
   for (genvar i = 0; i < TOT_W; i++) begin : g_bit
      localparam int unsigned    RK   = reg_of_bit(i, LO_W, OFS_W);
      localparam int unsigned    RB   = bit_in_reg(i, LO_W, OFS_W);
      localparam logic [1:0]     RSEL = 2'(RK);
      localparam logic [CNT_W-1:0] SIDX = CNT_W'(i);

      always_ff @(posedge clk or posedge rst) begin
         if (rst)
            ofs_vec[i] <= DEF_VEC[i];
         else if (ser_we && (ser_idx == SIDX))
            ofs_vec[i] <= si;
         else if (par_we && (par_sel == RSEL))
            ofs_vec[i] <= din[RB];
      end
   end
endmodule

// File: rtl/ofs_rd_mux.sv
module ofs_rd_mux #(
   parameter int LO_W   = 8,
   parameter int HI_W   = 7,
   parameter int DATA_W = 9,
   localparam int OFS_W = LO_W + HI_W,
   localparam int TOT_W = 2 * OFS_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic [1:0]        sel,
   input  logic [TOT_W-1:0]  ofs_vec,
   output logic [DATA_W-1:0] dout
);
   import ofsbank_pkg::*;

   logic [LO_W-1:0]   emp_lo, ful_lo;
   logic [HI_W-1:0]   emp_hi, ful_hi;
   logic [DATA_W-1:0] nxt;

   assign emp_lo = ofs_vec[LO_W-1:0];
   assign emp_hi = ofs_vec[OFS_W-1:LO_W];
   assign ful_lo = ofs_vec[OFS_W+LO_W-1:OFS_W];
   assign ful_hi = ofs_vec[TOT_W-1:OFS_W+LO_W];

   always_comb begin
      unique case (ofs_reg_e'(sel))
         REG_EMP_LO: nxt = DATA_W'(emp_lo);
         REG_EMP_HI: nxt = DATA_W'(emp_hi);
         REG_FUL_LO: nxt = DATA_W'(ful_lo);
         default:    nxt = DATA_W'(ful_hi);
      endcase
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)
         dout <= '0;
      else if (rd_en)
         dout <= nxt;
   end
endmodule

// File: rtl/ofs_bank.sv
module ofs_bank #(
   parameter int LO_W    = 8,
   parameter int HI_W    = 7,
   parameter int DATA_W  = 9,
   parameter int DEF_OFS = 127
) (
   input  logic                   wclk,
   input  logic                   rclk,
   input  logic                   mst_rst,
   input  logic                   part_rst,
   input  logic                   ld_n,
   input  logic                   sen_n,
   input  logic                   wen_n,
   input  logic                   ren_n,
   input  logic                   si,
   input  logic [DATA_W-1:0]      din,
   output logic [DATA_W-1:0]      dout,
   output logic [LO_W+HI_W-1:0]   empty_ofs,
   output logic [LO_W+HI_W-1:0]   full_ofs,
   output logic                   ser_done
);
   localparam int OFS_W = LO_W + HI_W;
   localparam int TOT_W = 2 * OFS_W;
   localparam int CNT_W = $clog2(TOT_W);

   if (LO_W < 1 || HI_W < 1) begin : g_bad_w
      $error("offset register widths must be positive");
   end
   if (LO_W > DATA_W || HI_W > DATA_W) begin : g_bad_bus
      $error("offset registers must fit the data bus");
   end
   if (DEF_OFS < 0 || DEF_OFS >= (1 << OFS_W)) begin : g_bad_def
      $error("default offset does not fit the offset width");
   end

   logic             ser_we, par_we, rd_en;
   logic [CNT_W-1:0] ser_idx;
   logic [1:0]       wptr, rptr;
   logic [TOT_W-1:0] ofs_vec;

   // Access decode: serial has priority over parallel, partial reset blocks all access.
   assign ser_we = !ld_n && !sen_n && !part_rst;
   assign par_we = !ld_n &&  sen_n && !wen_n && !part_rst;
   assign rd_en  = !ld_n && !ren_n && !part_rst;

   ofs_ser_ctr #(.TOT_W(TOT_W)) u_ser (
      .clk(wclk), .rst(mst_rst), .adv(ser_we), .idx(ser_idx), .done(ser_done)
   );

   ofs_seq_ptr #(.N_REG(ofsbank_pkg::N_OFS_REG)) u_wptr (
      .clk(wclk), .rst(mst_rst), .adv(par_we), .ptr(wptr)
   );

   ofs_seq_ptr #(.N_REG(ofsbank_pkg::N_OFS_REG)) u_rptr (
      .clk(rclk), .rst(mst_rst), .adv(rd_en), .ptr(rptr)
   );

   ofs_store #(.LO_W(LO_W), .HI_W(HI_W), .DATA_W(DATA_W), .DEF_OFS(DEF_OFS)) u_store (
      .clk(wclk), .rst(mst_rst), .ser_we(ser_we), .ser_idx(ser_idx), .si(si),
      .par_we(par_we), .par_sel(wptr), .din(din), .ofs_vec(ofs_vec)
   );

   ofs_rd_mux #(.LO_W(LO_W), .HI_W(HI_W), .DATA_W(DATA_W)) u_rd (
      .clk(rclk), .rst(mst_rst), .rd_en(rd_en), .sel(rptr), .ofs_vec(ofs_vec), .dout(dout)
   );

   assign empty_ofs = ofs_vec[OFS_W-1:0];
   assign full_ofs  = ofs_vec[TOT_W-1:OFS_W];
endmodule

// File: rtl/ofs_bank_chk.sv
module ofs_bank_chk #(
   parameter int LO_W   = 8,
   parameter int HI_W   = 7,
   parameter int DATA_W = 9,
   localparam int OFS_W = LO_W + HI_W,
   localparam int TOT_W = 2 * OFS_W,
   localparam int CNT_W = $clog2(TOT_W)
) (
   input logic              wclk,
   input logic              rclk,
   input logic              mst_rst,
   input logic              part_rst,
   input logic              ser_we,
   input logic              par_we,
   input logic              rd_en,
   input logic [CNT_W-1:0]  ser_idx,
   input logic [1:0]        wptr,
   input logic [1:0]        rptr,
   input logic              ser_done,
   input logic [DATA_W-1:0] dout,
   input logic [OFS_W-1:0]  empty_ofs,
   input logic [OFS_W-1:0]  full_ofs
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TOT_W - 1);

   AST_SER_STEP: assert property (@(posedge wclk) disable iff (mst_rst)
      ser_we && ser_idx != LAST |=> ser_idx == $past(ser_idx) + CNT_W'(1)); // R2
   AST_SER_WRAP: assert property (@(posedge wclk) disable iff (mst_rst)
      ser_we && ser_idx == LAST |=> ser_idx == '0 && ser_done); // R3
   AST_DONE_PULSE: assert property (@(posedge wclk) disable iff (mst_rst)
      ser_done |=> !ser_done); // R3
   AST_SER_HOLD: assert property (@(posedge wclk) disable iff (mst_rst)
      !ser_we |=> $stable(ser_idx)); // R4
   AST_OFS_HOLD: assert property (@(posedge wclk) disable iff (mst_rst)
      !ser_we && !par_we |=> $stable(empty_ofs) && $stable(full_ofs)); // R4
   AST_PAR_STEP: assert property (@(posedge wclk) disable iff (mst_rst)
      par_we |=> wptr == $past(wptr) + 2'd1); // R5
   AST_PAR_HOLD: assert property (@(posedge wclk) disable iff (mst_rst)
      !par_we |=> $stable(wptr)); // R7
   AST_SER_PRIO: assert property (@(posedge wclk) disable iff (mst_rst)
      ser_we |=> $stable(wptr)); // R8
   AST_RD_STEP: assert property (@(posedge rclk) disable iff (mst_rst)
      rd_en |=> rptr == $past(rptr) + 2'd1); // R9
   AST_RD_ZEXT: assert property (@(posedge rclk) disable iff (mst_rst)
      rd_en && rptr[0] |=> dout[DATA_W-1:HI_W] == '0); // R9
   AST_RD_HOLD: assert property (@(posedge rclk) disable iff (mst_rst)
      !rd_en |=> $stable(rptr) && $stable(dout)); // R10
   AST_PRST_HOLD: assert property (@(posedge wclk) disable iff (mst_rst)
      part_rst |=> $stable(wptr) && $stable(ser_idx)); // R11
endmodule

bind ofs_bank ofs_bank_chk #(.LO_W(LO_W), .HI_W(HI_W), .DATA_W(DATA_W)) u_chk (
   .wclk(wclk), .rclk(rclk), .mst_rst(mst_rst), .part_rst(part_rst),
   .ser_we(ser_we), .par_we(par_we), .rd_en(rd_en), .ser_idx(ser_idx),
   .wptr(wptr), .rptr(rptr), .ser_done(ser_done), .dout(dout),
   .empty_ofs(empty_ofs), .full_ofs(full_ofs)
);

// File: tb/sim_ofs_bank.sv
`timescale 1ns/1ps
module sim_ofs_bank;
   logic       wclk = 1'b0, rclk = 1'b1;
   logic       mst_rst = 1'b1, part_rst = 1'b0;
   logic       ld_n = 1'b1, sen_n = 1'b1, wen_n = 1'b1, ren_n = 1'b1, si = 1'b0;
   logic [8:0] din = '0;
   logic [8:0] dout;
   logic [14:0] empty_ofs, full_ofs;
   logic       ser_done;

   int nchk = 0, nerr = 0;
   bit finished = 0;

   // Bench model of the expected state, derived from the requirements.
   logic [29:0] exp_v;
   int wp, rp, sp;

   always #2 wclk = ~wclk;   // 250 MHz
   always #2 rclk = ~rclk;   // same rate, rising edges midway between wclk edges

   ofs_bank u0 (
      .wclk(wclk), .rclk(rclk), .mst_rst(mst_rst), .part_rst(part_rst),
      .ld_n(ld_n), .sen_n(sen_n), .wen_n(wen_n), .ren_n(ren_n), .si(si),
      .din(din), .dout(dout), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
      .ser_done(ser_done)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [8:0] exp_reg(int k);
      case (k)
         0: return {1'b0, exp_v[7:0]};
         1: return {2'b0, exp_v[14:8]};
         2: return {1'b0, exp_v[22:15]};
         default: return {2'b0, exp_v[29:23]};
      endcase
   endfunction

   task automatic chk_ofs(string tag);
      chk({tag, " empty"}, 32'(empty_ofs), 32'(exp_v[14:0]));
      chk({tag, " full"},  32'(full_ofs),  32'(exp_v[29:15]));
   endtask

   task automatic do_reset();
      @(posedge wclk); #1 mst_rst = 1'b1;
      @(posedge wclk); #1 mst_rst = 1'b0;
      exp_v = {15'd127, 15'd127};
      wp = 0; rp = 0; sp = 0;
   endtask

   // One write-domain cycle with the given controls, then back to idle.
   task automatic wop(logic l, logic s, logic w, logic b, logic [8:0] d);
      @(posedge wclk); #1;
      ld_n = l; sen_n = s; wen_n = w; si = b; din = d;
      @(posedge wclk); #1;
      ld_n = 1'b1; sen_n = 1'b1; wen_n = 1'b1;
   endtask

   task automatic shift_bit(logic b);
      wop(1'b0, 1'b0, 1'b1, b, 9'h000);
      exp_v[sp] = b;
      sp = (sp + 1) % 30;
   endtask

   task automatic pwr(logic [8:0] d);
      wop(1'b0, 1'b1, 1'b0, 1'b0, d);
      case (wp)
         0: exp_v[7:0]   = d[7:0];
         1: exp_v[14:8]  = d[6:0];
         2: exp_v[22:15] = d[7:0];
         default: exp_v[29:23] = d[6:0];
      endcase
      wp = (wp + 1) % 4;
   endtask

   task automatic rop(logic l, logic r);
      @(posedge rclk); #1;
      ld_n = l; ren_n = r;
      @(posedge rclk); #1;
      ld_n = 1'b1; ren_n = 1'b1;
   endtask

   task automatic rd(string tag);
      rop(1'b0, 1'b0);
      chk(tag, 32'(dout), 32'(exp_reg(rp)));
      rp = (rp + 1) % 4;
   endtask

   task automatic t_reset();
      do_reset();
      chk_ofs("R1 reset");
      chk("R1 reset dout", 32'(dout), 32'h0);
      chk("R1 reset ser_done", 32'(ser_done), 32'h0);
      for (int k = 0; k < 5; k++) rd("R1 R9 default readback");
   endtask

   task automatic t_parallel();
      do_reset();
      pwr(9'h1A5); pwr(9'h1FF); pwr(9'h13C); pwr(9'h155);
      chk("R5 R6 empty after 4 writes", 32'(empty_ofs), 32'h7FA5);
      chk("R5 R6 full after 4 writes",  32'(full_ofs),  32'h553C);
      pwr(9'h101);
      chk("R5 fifth write wraps to empty-low", 32'(empty_ofs), 32'h7F01);
      wop(1'b1, 1'b1, 1'b0, 1'b0, 9'h0EE);   // memory write
      chk_ofs("R7 ld_n high ignored");
      wop(1'b0, 1'b1, 1'b1, 1'b0, 9'h0EE);   // wen_n high
      chk_ofs("R7 wen_n high ignored");
      pwr(9'h003);
      chk("R7 resume at empty-high", 32'(empty_ofs), 32'h0301);
   endtask

   task automatic t_serial();
      logic [29:0] pat;
      pat = {15'h5A5A, 15'h1234};
      do_reset();
      for (int i = 0; i < 10; i++) shift_bit(pat[i]);
      chk_ofs("R2 partial serial load");
      wop(1'b0, 1'b1, 1'b1, ~pat[10], 9'h000);
      chk_ofs("R4 sen_n high ignored");
      wop(1'b1, 1'b0, 1'b1, ~pat[10], 9'h000);
      chk_ofs("R4 ld_n high ignored");
      for (int i = 10; i < 29; i++) shift_bit(pat[i]);
      chk("R3 no done before last bit", 32'(ser_done), 32'h0);
      shift_bit(pat[29]);
      chk("R3 done pulse after 30th bit", 32'(ser_done), 32'h1);
      chk("R2 serial empty", 32'(empty_ofs), 32'h1234);
      chk("R2 serial full",  32'(full_ofs),  32'h5A5A);
      @(posedge wclk); #1;
      chk("R3 done lasts one cycle", 32'(ser_done), 32'h0);
      shift_bit(~pat[0]);
      chk("R3 serial wraps to bit 0", 32'(empty_ofs), 32'(exp_v[14:0]));
   endtask

   task automatic t_priority();
      do_reset();
      wop(1'b0, 1'b0, 1'b0, 1'b0, 9'h0AA);
      exp_v[0] = 1'b0; sp = 1;
      chk("R8 serial wins", 32'(empty_ofs), 32'h007E);
      pwr(9'h055);
      chk("R8 parallel pointer unmoved", 32'(empty_ofs), 32'h0055);
   endtask

   task automatic t_readback();
      do_reset();
      pwr(9'h1C3); pwr(9'h1FF);
      rd("R10 read starts at empty-low after writes");
      pwr(9'h066); pwr(9'h1AB);
      rd("R9 empty-high zero-extended");
      rop(1'b1, 1'b0);                       // memory read
      chk("R10 dout held without access", 32'(dout), 32'(exp_reg(1)));
      rop(1'b0, 1'b1);
      chk("R10 dout held with ren_n high", 32'(dout), 32'(exp_reg(1)));
      rd("R10 resume at full-low");
      rd("R9 full-high");
      rd("R9 wrap to empty-low");
   endtask

   task automatic t_partial();
      do_reset();
      pwr(9'h0F0);
      @(posedge wclk); #1;
      part_rst = 1'b1; ld_n = 1'b0; wen_n = 1'b0; din = 9'h1EE;
      @(posedge wclk); #1;
      part_rst = 1'b0; ld_n = 1'b1; wen_n = 1'b1;
      chk_ofs("R11 no write during partial reset");
      pwr(9'h011);
      chk("R11 pointer kept", 32'(empty_ofs), 32'h11F0);
      rd("R11 read pointer kept");
      @(posedge rclk); #1;
      part_rst = 1'b1; ld_n = 1'b0; ren_n = 1'b0;
      @(posedge rclk); #1;
      part_rst = 1'b0; ld_n = 1'b1; ren_n = 1'b1;
      chk("R11 no readback during partial reset", 32'(dout), 32'(exp_reg(0)));
      rd("R11 readback continues");
   endtask

   task automatic t_mreset();
      do_reset();
      for (int i = 0; i < 5; i++) shift_bit(1'b0);
      pwr(9'h001);
      rd("R12 read before reset");
      do_reset();
      shift_bit(1'b0);
      chk("R12 serial restarts at bit 0", 32'(empty_ofs), 32'h007E);
      pwr(9'h022);
      chk("R12 parallel restarts at empty-low", 32'(empty_ofs), 32'h0022);
      rd("R12 readback restarts at empty-low");
   endtask

   initial begin
      t_reset();
      t_parallel();
      t_serial();
      t_priority();
      t_readback();
      t_partial();
      t_mreset();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      #400000;
      if (!finished) begin
         nchk++; nerr++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule